// File: doc/BRIEF.md
# Four-Channel DMA Register File and Host Port

This block is the software-visible side of a four-channel DMA controller. A host reaches it through a narrow 8-bit bus with an address, write data, a write strobe and a read strobe. Behind that port the block keeps the following state:

- a base copy and a current copy of a 16-bit address for each channel;
- a base copy and a current copy of a 16-bit count for each channel;
- a mode field and a page byte for each channel;
- a command byte;
- the channel mask bits;
- software request bits;
- terminal-count flags.

All of this state is presented in parallel to the channel engines. The engines feed back terminal-count pulses, raw request lines and current-register updates.

Every 16-bit register is reached through one byte-wide port. A single shared pointer bit picks the low or the high half of a 16-bit register. Each access to any channel address or count port flips that pointer. A dedicated write forces it back to the low half, so software can always restart a 16-bit sequence from a known point.

Mask bits can be changed in three ways: one channel at a time with an encoded write, all at once with a bitmap write, or all cleared together. A master-clear write returns the control state to idle but leaves the programmed addresses, counts and modes in place.

Top module: `dmac_regfile`

## Requirements
- R1: After reset, all four mask bits are 1, the command byte is 0, a status read returns 0x00 and the byte pointer selects the low byte.
- R2: Offset 2n is the address port of channel n, and offset 2n+1 is its count port (bus_addr[4]=0). Every read or write on offsets 0 to 7 moves the data through the low byte and then the high byte in turn, under one pointer shared by all eight ports.
- R3: A write of any data to offset 12 makes the next address or count access use the low byte.
- R4: An address or count write loads both the base copy and the current copy. Reads return the current copy. An engine update (eng_upd) changes only the current copy and leaves the base copy unchanged.
- R5: At offset 10, wdata[1:0] picks a channel; wdata[2]=1 masks that channel and wdata[2]=0 unmasks it. A write to offset 14 unmasks all channels. A write to offset 15 loads all masks from wdata[3:0].
- R6: At offset 11, wdata[1:0] picks a channel and wdata[7:2] becomes its 6-bit mode. The mode appears at cfg_mode[6n+5:6n]. Byte 0x44 means device-to-memory, 0x48 means memory-to-device, 0xC0 means cascade, and wdata[4] requests autoinitialise.
- R7: A read of offset 8 returns {requests[3:0], tc_flags[3:0]} and clears the terminal-count flags. A pulse on eng_tc[n] sets flag n, and it does so even in the cycle of a status read.
- R8: At offset 9, wdata[1:0] picks a channel and wdata[2] sets or clears its software request. Status bits 7:4 show the software request OR eng_dreq.
- R9: A write to offset 8 loads the command byte. A read of offset 8 returns status, never the command byte.
- R10: A write to offset 13 sets all masks and clears the command byte, the requests, the terminal-count flags and the byte pointer. Addresses, counts and modes are kept.
- R11: An eng_tc pulse on a channel whose mode has autoinitialise set reloads that channel's current address and count from its base copies on the next clock edge.
- R12: With bus_addr[4]=1, bus_addr[1:0] selects a channel's 8-bit page register for both reads and writes. Page accesses do not move the byte pointer.
- R13: A read of offset 13 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 5 | Register offset; bit 4 selects page space |
| bus_wdata | input | 8 | Host write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 8 | Read data for the addressed register (combinational) |
| eng_tc | input | 4 | Terminal-count pulses from the engines |
| eng_dreq | input | 4 | Raw request lines from the engines |
| eng_upd | input | 4 | Load current address and count from the engine |
| eng_upd_addr | input | 64 | New current addresses, channel n at [16n+15:16n] |
| eng_upd_cnt | input | 64 | New current counts, channel n at [16n+15:16n] |
| cfg_cmd | output | 8 | Command byte |
| cfg_mask | output | 4 | Mask bits, 1 = masked |
| cfg_mode | output | 24 | Mode fields, channel n at [6n+5:6n] |
| cfg_page | output | 32 | Page bytes, channel n at [8n+7:8n] |
| cfg_base_addr | output | 64 | Base addresses |
| cfg_base_cnt | output | 64 | Base counts |
| cfg_cur_addr | output | 64 | Current addresses |
| cfg_cur_cnt | output | 64 | Current counts |

## Verification
The hardest state to reach from the ports is a byte pointer that disagrees with what the host expects. It arises from an odd number of accesses, from page accesses placed between the two halves, or from a master clear issued while the pointer selects the high byte. The stimulus deliberately leaves the pointer on the high byte before each clear. It also places a page write between the two halves of an address write, so that a stray toggle shows up as swapped bytes. A second corner is a terminal-count pulse that lands in the same cycle as a status read. The bench drives both together and then checks that the flag survives into the next read.

// File: rtl/dmac_pkg.sv
// Shared constants and helpers for the DMA register file.
// Assumes four channels, so a channel number fits in two data bits.
package dmac_pkg;
    localparam int NUM_CH   = 4;
    localparam int BYTE_W   = 8;
    localparam int WORD_W   = 16;
    localparam int CH_W     = $clog2(NUM_CH);
    localparam int MODE_W   = BYTE_W - CH_W;
    localparam int ADDR_W   = 5;
    localparam int OFS_W    = 4;

    // Control offsets in the register space (bus_addr[4] = 0)
    localparam logic [OFS_W-1:0] OFS_CMD_STAT  = 4'd8;
    localparam logic [OFS_W-1:0] OFS_REQ       = 4'd9;
    localparam logic [OFS_W-1:0] OFS_MASK_ONE  = 4'd10;
    localparam logic [OFS_W-1:0] OFS_MODE      = 4'd11;
    localparam logic [OFS_W-1:0] OFS_PTR_CLR   = 4'd12;
    localparam logic [OFS_W-1:0] OFS_MCLR_TEMP = 4'd13;
    localparam logic [OFS_W-1:0] OFS_MASK_NONE = 4'd14;
    localparam logic [OFS_W-1:0] OFS_MASK_ALL  = 4'd15;

    // Bit of the stored mode field that requests autoinitialise
    localparam int MODE_AUTO_BIT = 4 - CH_W;
    // Data bit that carries set/clear in encoded single-channel writes
    localparam int SET_BIT = 2;

    // Replace the low or high byte of a word
    function automatic logic [WORD_W-1:0] put_byte(input logic [WORD_W-1:0] old,
                                                   input logic hi,
                                                   input logic [BYTE_W-1:0] b);
        return hi ? {b, old[BYTE_W-1:0]} : {old[WORD_W-1:BYTE_W], b};
    endfunction
endpackage

// File: rtl/dmac_byteptr.sv
// Shared low/high byte pointer for all 16-bit ports.
// Assumes 'access' pulses once per host read or write on an address/count port.
module dmac_byteptr (
    input  logic clk,
    input  logic rst_n,
    input  logic access,
    input  logic clear,
    output logic hi
);
    // Toggle on each access; a clear wins and selects the low byte
    always_ff @(posedge clk) begin
        if (!rst_n)      hi <= 1'b0;
        else if (clear)  hi <= 1'b0;
        else if (access) hi <= ~hi;
    end

    p_ptr_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !hi);
    p_ptr_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (access && !clear) |=> (hi != $past(hi)));
endmodule

// File: rtl/dmac_chan.sv
// Per-channel state: base/current address and count, mode, page.
// Assumes at most one host write strobe per cycle. Priority for the current copies
// is host write, then autoinitialise reload, then engine update.
module dmac_chan
    import dmac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_addr,
    input  logic              wr_cnt,
    input  logic              wr_mode,
    input  logic              wr_page,
    input  logic              hi_byte,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              tc,
    input  logic              upd,
    input  logic [WORD_W-1:0] upd_addr,
    input  logic [WORD_W-1:0] upd_cnt,
    output logic [WORD_W-1:0] base_addr,
    output logic [WORD_W-1:0] base_cnt,
    output logic [WORD_W-1:0] cur_addr,
    output logic [WORD_W-1:0] cur_cnt,
    output logic [MODE_W-1:0] mode,
    output logic [BYTE_W-1:0] page
);
    logic reload;
    assign reload = tc && mode[MODE_AUTO_BIT];

    // Address: host byte writes load both copies; reload/update touch current only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_addr <= '0;
            cur_addr  <= '0;
        end else if (wr_addr) begin
            base_addr <= put_byte(base_addr, hi_byte, wdata);
            cur_addr  <= put_byte(cur_addr, hi_byte, wdata);
        end else if (reload) begin
            cur_addr  <= base_addr;
        end else if (upd) begin
            cur_addr  <= upd_addr;
        end
    end

    // Count: same policy as the address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_cnt <= '0;
            cur_cnt  <= '0;
        end else if (wr_cnt) begin
            base_cnt <= put_byte(base_cnt, hi_byte, wdata);
            cur_cnt  <= put_byte(cur_cnt, hi_byte, wdata);
        end else if (reload) begin
            cur_cnt  <= base_cnt;
        end else if (upd) begin
            cur_cnt  <= upd_cnt;
        end
    end

    // Mode field and page byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= '0;
            page <= '0;
        end else begin
            if (wr_mode) mode <= wdata[BYTE_W-1:CH_W];
            if (wr_page) page <= wdata;
        end
    end

    p_base_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_addr |=> $stable(base_addr));
    p_reload_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (tc && mode[MODE_AUTO_BIT] && !wr_addr && !wr_cnt)
            |=> (cur_addr == $past(base_addr)) && (cur_cnt == $past(base_cnt)));
endmodule

// File: rtl/dmac_ctrl.sv
// Shared control state: command byte, masks, software requests, terminal-count flags.
// Assumes write strobes are mutually exclusive one-cycle pulses.
module dmac_ctrl
    import dmac_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_cmd,
    input  logic                wr_req,
    input  logic                wr_mask_one,
    input  logic                wr_mask_none,
    input  logic                wr_mask_all,
    input  logic                wr_mclr,
    input  logic                rd_stat,
    input  logic [BYTE_W-1:0]   wdata,
    input  logic [NUM_CH-1:0]   tc,
    input  logic [NUM_CH-1:0]   dreq,
    output logic [BYTE_W-1:0]   cmd,
    output logic [NUM_CH-1:0]   mask,
    output logic [2*NUM_CH-1:0] status
);
    logic [NUM_CH-1:0] sreq;
    logic [NUM_CH-1:0] tcf;
    logic [CH_W-1:0]   sel;

    assign sel    = wdata[CH_W-1:0];
    assign status = {sreq | dreq, tcf};

    // Command byte
    always_ff @(posedge clk) begin
        if (!rst_n || wr_mclr) cmd <= '0;
        else if (wr_cmd)       cmd <= wdata;
    end

    // Mask bits: single encoded, clear-all and bitmap writes
    always_ff @(posedge clk) begin
        if (!rst_n || wr_mclr) mask <= '1;
        else if (wr_mask_none) mask <= '0;
        else if (wr_mask_all)  mask <= wdata[NUM_CH-1:0];
        else if (wr_mask_one)  mask[sel] <= wdata[SET_BIT];
    end

    // Software request bits
    always_ff @(posedge clk) begin
        if (!rst_n || wr_mclr) sreq <= '0;
        else if (wr_req)       sreq[sel] <= wdata[SET_BIT];
    end

    // Terminal-count flags: cleared by status read, new pulses always land
    always_ff @(posedge clk) begin
        if (!rst_n) tcf <= '0;
        else        tcf <= ((wr_mclr || rd_stat) ? '0 : tcf) | tc;
    end

    p_mclr_masks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mclr |=> (&mask) && (cmd == '0) && (sreq == '0));
    p_tc_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|tc) |=> ((tcf & $past(tc)) == $past(tc)));
    p_stat_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && tc == '0) |=> (tcf == '0));
endmodule

// File: rtl/dmac_regfile.sv
// Host-facing register file of a four-channel DMA controller.
// Decodes the 8-bit bus, owns the shared byte pointer and the read mux, and
// fans channel state out to the engines. Assumes bus_wr and bus_rd are never
// high together and each stays high for one cycle per access.
module dmac_regfile
    import dmac_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [BYTE_W-1:0]          bus_wdata,
    input  logic                       bus_wr,
    input  logic                       bus_rd,
    output logic [BYTE_W-1:0]          bus_rdata,
    input  logic [NUM_CH-1:0]          eng_tc,
    input  logic [NUM_CH-1:0]          eng_dreq,
    input  logic [NUM_CH-1:0]          eng_upd,
    input  logic [NUM_CH*WORD_W-1:0]   eng_upd_addr,
    input  logic [NUM_CH*WORD_W-1:0]   eng_upd_cnt,
    output logic [BYTE_W-1:0]          cfg_cmd,
    output logic [NUM_CH-1:0]          cfg_mask,
    output logic [NUM_CH*MODE_W-1:0]   cfg_mode,
    output logic [NUM_CH*BYTE_W-1:0]   cfg_page,
    output logic [NUM_CH*WORD_W-1:0]   cfg_base_addr,
    output logic [NUM_CH*WORD_W-1:0]   cfg_base_cnt,
    output logic [NUM_CH*WORD_W-1:0]   cfg_cur_addr,
    output logic [NUM_CH*WORD_W-1:0]   cfg_cur_cnt
);
    logic              reg_space;
    logic [OFS_W-1:0]  ofs;
    logic              word_port;
    logic [CH_W-1:0]   port_ch;
    logic              ptr_hi;
    logic              ptr_clear;
    logic              wr_mclr;
    logic [2*NUM_CH-1:0] status;

    logic [WORD_W-1:0] cur_addr_a [NUM_CH];
    logic [WORD_W-1:0] cur_cnt_a  [NUM_CH];
    logic [BYTE_W-1:0] page_a     [NUM_CH];

    assign reg_space = !bus_addr[ADDR_W-1];
    assign ofs       = bus_addr[OFS_W-1:0];
    assign word_port = reg_space && !ofs[OFS_W-1];
    assign port_ch   = ofs[CH_W:1];
    assign wr_mclr   = bus_wr && reg_space && (ofs == OFS_MCLR_TEMP);
    assign ptr_clear = wr_mclr || (bus_wr && reg_space && (ofs == OFS_PTR_CLR));

    dmac_byteptr u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .access ((bus_wr || bus_rd) && word_port),
        .clear  (ptr_clear),
        .hi     (ptr_hi)
    );

    dmac_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_cmd       (bus_wr && reg_space && (ofs == OFS_CMD_STAT)),
        .wr_req       (bus_wr && reg_space && (ofs == OFS_REQ)),
        .wr_mask_one  (bus_wr && reg_space && (ofs == OFS_MASK_ONE)),
        .wr_mask_none (bus_wr && reg_space && (ofs == OFS_MASK_NONE)),
        .wr_mask_all  (bus_wr && reg_space && (ofs == OFS_MASK_ALL)),
        .wr_mclr      (wr_mclr),
        .rd_stat      (bus_rd && reg_space && (ofs == OFS_CMD_STAT)),
        .wdata        (bus_wdata),
        .tc           (eng_tc),
        .dreq         (eng_dreq),
        .cmd          (cfg_cmd),
        .mask         (cfg_mask),
        .status       (status)
    );

    // One channel slice per channel, with its own write decode
    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        logic sel_port;
        assign sel_port = bus_wr && word_port && (port_ch == CH_W'(n));

        dmac_chan u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_addr   (sel_port && !ofs[0]),
            .wr_cnt    (sel_port && ofs[0]),
            .wr_mode   (bus_wr && reg_space && (ofs == OFS_MODE)
                        && (bus_wdata[CH_W-1:0] == CH_W'(n))),
            .wr_page   (bus_wr && !reg_space && (bus_addr[CH_W-1:0] == CH_W'(n))),
            .hi_byte   (ptr_hi),
            .wdata     (bus_wdata),
            .tc        (eng_tc[n]),
            .upd       (eng_upd[n]),
            .upd_addr  (eng_upd_addr[n*WORD_W +: WORD_W]),
            .upd_cnt   (eng_upd_cnt[n*WORD_W +: WORD_W]),
            .base_addr (cfg_base_addr[n*WORD_W +: WORD_W]),
            .base_cnt  (cfg_base_cnt[n*WORD_W +: WORD_W]),
            .cur_addr  (cur_addr_a[n]),
            .cur_cnt   (cur_cnt_a[n]),
            .mode      (cfg_mode[n*MODE_W +: MODE_W]),
            .page      (page_a[n])
        );

        assign cfg_cur_addr[n*WORD_W +: WORD_W] = cur_addr_a[n];
        assign cfg_cur_cnt[n*WORD_W +: WORD_W]  = cur_cnt_a[n];
        assign cfg_page[n*BYTE_W +: BYTE_W]     = page_a[n];
    end

    // Read mux: current word byte, status, or page; everything else reads zero
    always_comb begin
        logic [WORD_W-1:0] word;
        word      = ofs[0] ? cur_cnt_a[port_ch] : cur_addr_a[port_ch];
        bus_rdata = '0;
        if (!reg_space)
            bus_rdata = page_a[bus_addr[CH_W-1:0]];
        else if (word_port)
            bus_rdata = ptr_hi ? word[WORD_W-1:BYTE_W] : word[BYTE_W-1:0];
        else if (ofs == OFS_CMD_STAT)
            bus_rdata = status;
    end

    p_mclr_ptr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mclr |=> !ptr_hi);
endmodule

// File: tb/sim_dmac_regfile.sv
`timescale 1ns/1ps
module sim_dmac_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic [3:0]  eng_tc = '0;
    logic [3:0]  eng_dreq = '0;
    logic [3:0]  eng_upd = '0;
    logic [63:0] eng_upd_addr = '0;
    logic [63:0] eng_upd_cnt = '0;
    logic [7:0]  cfg_cmd;
    logic [3:0]  cfg_mask;
    logic [23:0] cfg_mode;
    logic [31:0] cfg_page;
    logic [63:0] cfg_base_addr, cfg_base_cnt, cfg_cur_addr, cfg_cur_cnt;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dmac_regfile u0 (.*);

    // Vector: {is_read, req, addr, wdata, expected read data}
    localparam int NV = 27;
    localparam logic [25:0] VEC [NV] = '{
        {1'b1, 4'd1,  5'h08, 8'h00, 8'h00},
        {1'b0, 4'd3,  5'h0C, 8'h5A, 8'h00},
        {1'b0, 4'd2,  5'h00, 8'h34, 8'h00},
        {1'b0, 4'd2,  5'h00, 8'h12, 8'h00},
        {1'b1, 4'd2,  5'h00, 8'h00, 8'h34},
        {1'b1, 4'd2,  5'h00, 8'h00, 8'h12},
        {1'b0, 4'd2,  5'h03, 8'hFF, 8'h00},
        {1'b0, 4'd2,  5'h03, 8'h00, 8'h00},
        {1'b1, 4'd2,  5'h03, 8'h00, 8'hFF},
        {1'b1, 4'd2,  5'h03, 8'h00, 8'h00},
        {1'b0, 4'd3,  5'h04, 8'hAB, 8'h00},
        {1'b0, 4'd3,  5'h0C, 8'h00, 8'h00},
        {1'b1, 4'd3,  5'h04, 8'h00, 8'hAB},
        {1'b1, 4'd3,  5'h04, 8'h00, 8'h00},
        {1'b0, 4'd12, 5'h06, 8'h11, 8'h00},
        {1'b0, 4'd12, 5'h13, 8'h99, 8'h00},
        {1'b0, 4'd12, 5'h06, 8'h22, 8'h00},
        {1'b1, 4'd12, 5'h06, 8'h00, 8'h11},
        {1'b1, 4'd12, 5'h06, 8'h00, 8'h22},
        {1'b1, 4'd12, 5'h13, 8'h00, 8'h99},
        {1'b0, 4'd8,  5'h09, 8'h06, 8'h00},
        {1'b1, 4'd8,  5'h08, 8'h00, 8'h40},
        {1'b0, 4'd8,  5'h09, 8'h02, 8'h00},
        {1'b1, 4'd8,  5'h08, 8'h00, 8'h00},
        {1'b1, 4'd13, 5'h0D, 8'h00, 8'h00},
        {1'b0, 4'd9,  5'h08, 8'hA5, 8'h00},
        {1'b1, 4'd9,  5'h08, 8'h00, 8'h00}
    };

    task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d actual %h expected %h", req, act, exp);
        end
    endtask

    // Called at a negedge; returns at the next negedge
    task automatic bus_write(input logic [4:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1 bus_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk); #1 bus_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic read_check(input int req, input logic [4:0] a, input logic [7:0] exp);
        logic [7:0] d;
        bus_read(a, d);
        check(req, {24'd0, d}, {24'd0, exp});
    endtask

    task automatic pulse_tc(input logic [3:0] t);
        eng_tc = t;
        @(posedge clk); #1 eng_tc = '0;
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog (all requirements) actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check(1, {28'd0, cfg_mask}, 32'hF);
        check(1, {24'd0, cfg_cmd}, 32'h0);

        // Table walk: R2 R3 R8 R9 R12 R13
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][25]) read_check(int'(VEC[i][24:21]), VEC[i][20:16], VEC[i][7:0]);
            else            bus_write(VEC[i][20:16], VEC[i][15:8]);
        end
        check(9, {24'd0, cfg_cmd}, 32'hA5);

        // R5 masks
        bus_write(5'h0A, 8'h01); check(5, {28'd0, cfg_mask}, 32'hD);
        bus_write(5'h0A, 8'h05); check(5, {28'd0, cfg_mask}, 32'hF);
        bus_write(5'h0E, 8'h00); check(5, {28'd0, cfg_mask}, 32'h0);
        bus_write(5'h0F, 8'h0A); check(5, {28'd0, cfg_mask}, 32'hA);

        // R6 modes
        bus_write(5'h0B, 8'h4A); check(6, {26'd0, cfg_mode[17:12]}, 32'h12);
        bus_write(5'h0B, 8'hC3); check(6, {26'd0, cfg_mode[23:18]}, 32'h30);

        // R7 terminal count flags, including a pulse during the status read
        pulse_tc(4'b0100);
        read_check(7, 5'h08, 8'h04);
        read_check(7, 5'h08, 8'h00);
        eng_tc = 4'b0001;
        bus_read(5'h08, d);
        eng_tc = '0;
        check(7, {24'd0, d}, 32'h00);
        read_check(7, 5'h08, 8'h01);

        // R8 hardware request lines
        eng_dreq = 4'b1000;
        #1 read_check(8, 5'h08, 8'h80);
        eng_dreq = '0;

        // R4 engine update hits current copy only
        eng_upd_addr[15:0] = 16'hBEEF; eng_upd = 4'b0001;
        @(posedge clk); #1 eng_upd = '0; @(negedge clk);
        read_check(4, 5'h00, 8'hEF);
        read_check(4, 5'h00, 8'hBE);
        check(4, {16'd0, cfg_base_addr[15:0]}, 32'h1234);

        // R11 autoinitialise reload on terminal count
        bus_write(5'h0B, 8'h54);
        pulse_tc(4'b0001);
        check(11, {16'd0, cfg_cur_addr[15:0]}, 32'h1234);
        read_check(7, 5'h08, 8'h01);

        // R10 master clear with the pointer on the high byte
        bus_write(5'h02, 8'h00);
        bus_write(5'h09, 8'h05);
        bus_write(5'h0D, 8'h00);
        check(10, {28'd0, cfg_mask}, 32'hF);
        check(10, {24'd0, cfg_cmd}, 32'h0);
        read_check(10, 5'h08, 8'h00);
        read_check(10, 5'h00, 8'h34);
        check(10, {26'd0, cfg_mode[17:12]}, 32'h12);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule